// File: doc/BRIEF.md
# Link Start-up Transmitter Enable Controller

This block sits beside the start-up state machine of a serial radio-link port and decides when that port's optical transmitter may emit light. It observes the current start-up state (A through G), whether the port is the master or the slave end of the link, and the receive-side indicators for detected light and hyperframe synchronisation. From these it drives a registered transmit enable. A master lights up as soon as start-up reaches state B. A slave stays dark in state B until it has both seen light and gained hyperframe sync. Both roles transmit in every later state.

The block also runs two timers clocked by a shared timebase tick. The layer-1 start-up timer counts from the moment start-up leaves state A and flags expiry after a parameterised number of ticks, about 10 s in a real system. A negotiation-complete pulse clears and parks it until the link falls back to state A. The sync-attempt timer measures how long a slave has spent in state B without hyperframe sync. It flags a timeout after a window of at least 10 minutes. The decisions about state transitions are left to the surrounding logic.

Top module: `linkup_tx_ctrl`

## Requirements
- R1: With state code 0 (state A), the transmit enable is low one cycle later for either role; state code 7 is also treated as dark.
- R2: With role input high (master) and state code 1 (state B), the transmit enable is high one cycle later.
- R3: A slave (role input low) in state B keeps the transmit enable low unless light-detect and hyperframe-sync are both high in the same cycle.
- R4: Once a slave in state B has lit its transmitter, it stays lit while the state remains B, even if sync or light is then lost.
- R5: With state codes 2 to 6 (states C to G), the transmit enable is high one cycle later for either role.
- R6: Outside state A, the start-up-expired flag rises in the cycle after the STARTUP_TICKS-th tick, is low after one tick fewer, and stays high until cleared.
- R7: Clock cycles without a tick pulse do not advance either timer.
- R8: A negotiation-complete pulse clears the start-up-expired flag and holds the start-up timer cleared until the state returns to A.
- R9: A slave in state B without hyperframe sync raises the sync-timeout flag in the cycle after the SYNC_TICKS-th tick and not before.
- R10: Hyperframe sync restarts the sync-attempt window, and a master never raises the sync-timeout flag.
- R11: Returning to state A drops both flags and restarts both timers from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_master | input | 1 | 1 = master port, 0 = slave port |
| su_state | input | 3 | Start-up state: 0..6 = A..G |
| light_det | input | 1 | Incoming light detected |
| hfn_sync | input | 1 | Hyperframe synchronisation reached |
| nego_done | input | 1 | Pulse: all start-up negotiations complete |
| tick | input | 1 | Timebase pulse, one clock wide |
| tx_en | output | 1 | Optical transmitter enable |
| l1_expired | output | 1 | Start-up timer expired (sticky) |
| sync_timeout | output | 1 | Slave sync-attempt window exhausted (sticky) |

## Verification
The checks assume that the start-up state is held for at least one clock before the transmit enable is judged, and that tick and nego_done are single-clock pulses. The stimulus changes every input on the falling clock edge and keeps each state for several cycles. It shortens both timer limits so that exact expiry edges can be counted tick by tick. Tick pulses are spaced with idle cycles between them, so the counting covers cycles in which the clock runs but no tick arrives.

// File: rtl/linkup_pkg.sv
package linkup_pkg;

  typedef enum logic [2:0] {
    SU_A   = 3'd0,
    SU_B   = 3'd1,
    SU_C   = 3'd2,
    SU_D   = 3'd3,
    SU_E   = 3'd4,
    SU_F   = 3'd5,
    SU_G   = 3'd6,
    SU_BAD = 3'd7
  } su_state_e;

endpackage

// File: rtl/linkup_tick_timer.sv
module linkup_tick_timer #(
  parameter int unsigned LIMIT = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic expired
);
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          exp_q, exp_d;
  logic          adv;

  assign adv = run && tick && !exp_q;

  always_comb begin
    cnt_d = cnt_q;
    exp_d = exp_q;
    if (clr) begin
      cnt_d = '0;
      exp_d = 1'b0;
    end else if (adv) begin
      if (cnt_q == LAST) begin
        exp_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (clr || adv) begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign expired = exp_q;

endmodule

// File: rtl/linkup_tx_gate.sv
module linkup_tx_gate
  import linkup_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      is_master,
  input  su_state_e st,
  input  logic      light_det,
  input  logic      hfn_sync,
  output logic      tx_en
);
  logic tx_q, tx_d;
  logic lit_q, lit_d;
  logic slave_ready;

  assign slave_ready = light_det && hfn_sync;

  always_comb begin
    lit_d = 1'b0;
    unique case (st)
      SU_A, SU_BAD: tx_d = 1'b0;
      SU_B: begin
        if (is_master) begin
          tx_d = 1'b1;
        end else begin
          lit_d = lit_q || slave_ready;
          tx_d  = lit_d;
        end
      end
      default: tx_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= 1'b0;
      lit_q <= 1'b0;
    end else begin
      tx_q  <= tx_d;
      lit_q <= lit_d;
    end
  end

  assign tx_en = tx_q;

endmodule

// File: rtl/linkup_tx_ctrl.sv
module linkup_tx_ctrl
  import linkup_pkg::*;
#(
  parameter int unsigned STARTUP_TICKS = 10000,
  parameter int unsigned SYNC_TICKS    = 600000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       is_master,
  input  logic [2:0] su_state,
  input  logic       light_det,
  input  logic       hfn_sync,
  input  logic       nego_done,
  input  logic       tick,
  output logic       tx_en,
  output logic       l1_expired,
  output logic       sync_timeout
);
  su_state_e st;
  logic      in_a, in_b;
  logic      nego_seen_q, nego_seen_d;
  logic      su_clr, sy_clr;

  assign st   = su_state_e'(su_state);
  assign in_a = (st == SU_A);
  assign in_b = (st == SU_B);

  always_comb begin
    nego_seen_d = nego_seen_q;
    if (in_a)           nego_seen_d = 1'b0;
    else if (nego_done) nego_seen_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nego_seen_q <= 1'b0;
    else        nego_seen_q <= nego_seen_d;
  end

  assign su_clr = in_a || nego_done || nego_seen_q;
  assign sy_clr = is_master || !in_b || hfn_sync;

  linkup_tx_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .is_master (is_master),
    .st        (st),
    .light_det (light_det),
    .hfn_sync  (hfn_sync),
    .tx_en     (tx_en)
  );

  linkup_tick_timer #(.LIMIT(STARTUP_TICKS)) u_su_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (su_clr),
    .run     (!in_a),
    .tick    (tick),
    .expired (l1_expired)
  );

  linkup_tick_timer #(.LIMIT(SYNC_TICKS)) u_sy_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (sy_clr),
    .run     (1'b1),
    .tick    (tick),
    .expired (sync_timeout)
  );

endmodule

// File: rtl/linkup_tx_ctrl_sva.sv
module linkup_tx_ctrl_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       is_master,
  input logic [2:0] su_state,
  input logic       light_det,
  input logic       hfn_sync,
  input logic       nego_done,
  input logic       tx_en,
  input logic       l1_expired,
  input logic       sync_timeout
);

  assert_state_a_dark_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (su_state == 3'd0) |=> !tx_en);

  assert_master_b_lit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && su_state == 3'd1) |=> tx_en);

  assert_slave_b_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && su_state == 3'd1 && !tx_en && !(light_det && hfn_sync)) |=> !tx_en);

  assert_slave_b_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && su_state == 3'd1 && tx_en) |=> tx_en);

  assert_later_states_lit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (su_state >= 3'd2 && su_state <= 3'd6) |=> tx_en);

  assert_expiry_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_expired && su_state != 3'd0 && !nego_done) |=> l1_expired);

  assert_nego_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nego_done |=> !l1_expired);

  assert_master_no_timeout_R10: assert property (@(posedge clk) disable iff (!rst_n)
    is_master |=> !sync_timeout);

  assert_state_a_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (su_state == 3'd0) |=> (!l1_expired && !sync_timeout));

endmodule

bind linkup_tx_ctrl linkup_tx_ctrl_sva u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .is_master    (is_master),
  .su_state     (su_state),
  .light_det    (light_det),
  .hfn_sync     (hfn_sync),
  .nego_done    (nego_done),
  .tx_en        (tx_en),
  .l1_expired   (l1_expired),
  .sync_timeout (sync_timeout)
);

// File: tb/linkup_tx_ctrl_tb.sv
module linkup_tx_ctrl_tb;
  localparam int unsigned SU_N = 20;
  localparam int unsigned SY_N = 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       is_master = 1'b0;
  logic [2:0] su_state = 3'd0;
  logic       light_det = 1'b0;
  logic       hfn_sync = 1'b0;
  logic       nego_done = 1'b0;
  logic       tick = 1'b0;
  logic       tx_en, l1_expired, sync_timeout;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  linkup_tx_ctrl #(.STARTUP_TICKS(SU_N), .SYNC_TICKS(SY_N)) u_dut (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .su_state(su_state),
    .light_det(light_det), .hfn_sync(hfn_sync), .nego_done(nego_done),
    .tick(tick), .tx_en(tx_en), .l1_expired(l1_expired),
    .sync_timeout(sync_timeout)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic go(input logic m, input logic [2:0] s);
    @(negedge clk);
    is_master = m;
    su_state  = s;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    chk("reset tx", tx_en, 1'b0);
    chk("reset exp", l1_expired, 1'b0);
    chk("reset sto", sync_timeout, 1'b0);
    @(negedge clk) rst_n = 1'b1;

    // R1, R2, R5: sweep every state code for both roles
    for (int r = 0; r < 2; r++) begin
      for (int s = 0; s < 8; s++) begin
        go(1'b0, 3'd0);
        light_det = 1'b1; hfn_sync = 1'b1;
        go(r[0], s[2:0]);
        if (s == 0 || s == 7)
          chk("R1", tx_en, 1'b0);
        else if (s == 1)
          chk("R2", tx_en, 1'b1);
        else
          chk("R5", tx_en, 1'b1);
      end
    end

    // R3: slave in B, all light/sync combinations
    for (int c = 0; c < 4; c++) begin
      go(1'b0, 3'd0);
      light_det = c[0]; hfn_sync = c[1];
      go(1'b0, 3'd1);
      idle(2);
      chk("R3", tx_en, (c == 3) ? 1'b1 : 1'b0);
    end

    // R4: lit slave stays lit after losing sync and light
    @(negedge clk) begin hfn_sync = 1'b0; light_det = 1'b0; end
    idle(3);
    chk("R4", tx_en, 1'b1);
    go(1'b0, 3'd0);
    chk("R1 back to A", tx_en, 1'b0);

    // R6: start-up timer exact expiry, master in B
    hfn_sync = 1'b1;
    go(1'b1, 3'd1);
    ticks(SU_N - 1);
    chk("R6 before", l1_expired, 1'b0);
    ticks(1);
    chk("R6 at limit", l1_expired, 1'b1);
    ticks(3);
    chk("R6 sticky", l1_expired, 1'b1);

    // R8: negotiation complete clears and parks the timer
    go(1'b1, 3'd4);
    @(negedge clk) nego_done = 1'b1;
    @(negedge clk) nego_done = 1'b0;
    chk("R8 cleared", l1_expired, 1'b0);
    ticks(SU_N * 2);
    chk("R8 parked", l1_expired, 1'b0);

    // R11: state A restarts the start-up timer
    go(1'b1, 3'd0);
    go(1'b1, 3'd2);
    ticks(SU_N - 1);
    chk("R11 restart before", l1_expired, 1'b0);
    ticks(1);
    chk("R11 restart at limit", l1_expired, 1'b1);
    go(1'b1, 3'd0);
    chk("R11 flag drop", l1_expired, 1'b0);

    // R9, R7: slave sync window with idle gaps
    hfn_sync = 1'b0; light_det = 1'b0;
    go(1'b0, 3'd1);
    ticks(25);
    idle(200);
    chk("R7 idle no timeout", sync_timeout, 1'b0);
    ticks(SY_N - 26);
    chk("R9 before", sync_timeout, 1'b0);
    ticks(1);
    chk("R9 at limit", sync_timeout, 1'b1);
    chk("R3 still dark", tx_en, 1'b0);
    go(1'b0, 3'd0);
    chk("R11 timeout drop", sync_timeout, 1'b0);

    // R10: sync pulse restarts the window
    go(1'b0, 3'd1);
    ticks(30);
    @(negedge clk) hfn_sync = 1'b1;
    @(negedge clk) hfn_sync = 1'b0;
    ticks(SY_N - 1);
    chk("R10 restart before", sync_timeout, 1'b0);
    ticks(1);
    chk("R10 restart at limit", sync_timeout, 1'b1);

    // R10: master never times out
    go(1'b1, 3'd0);
    go(1'b1, 3'd1);
    ticks(SY_N + 10);
    chk("R10 master", sync_timeout, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule